// File: doc/BRIEF.md
# Switch Power-Up Bring-Up Sequencer

This controller runs the start-up of a time-division-multiplexed switch after power is applied. While the supply is not good, and through the whole bring-up, it keeps the serial outputs disabled, shows the high-impedance indicator, and holds the test-port reset low. When power-good rises it drives the device reset low for slightly longer than one microsecond and then releases it. It then waits for the device to stabilize. The length of this wait depends on the selected input clock frequency and on whether an external oscillator is fitted.

After the stabilization wait, the sequencer issues one control-register write that carries the clock-frequency code. It then waits at least 500 µs before any further access. Next it asks the connection-memory programming logic to run its block-programming phase. Only after that logic reports completion are the outputs enabled and the done flag raised. A drop of power-good at any point aborts the sequence and restarts it from the reset pulse.

All waits are counted in system clock cycles. They are derived from the parameter `CLK_KHZ`, the system clock frequency in kHz. The register write is a valid/ready transfer. Once `wr_valid_o` is high, the address and data stay stable until a cycle in which `wr_ready_i` is also high. The transfer completes on that edge, and the receiver may apply back-pressure for any number of cycles. The programming phase uses a plain request/done pair.

Top module: `pwrseq_top`

## Requirements
- R1: `out_en_o` is low and `hiz_ind_o` is high whenever the sequence has not finished, including while `pwr_good_i` is low; the two outputs are always complementary.
- R2: `tap_rst_n_o` is low from power-good loss until the sequence finishes, and high only once it has finished.
- R3: After `pwr_good_i` rises, `dev_rst_n_o` stays low for RST_CYC = CLK_KHZ/1000 + 1 rising clock edges, which is more than 1 µs, and then goes high.
- R4: After `dev_rst_n_o` rises, `wr_valid_o` rises after STAB cycles, with BASE = CLK_KHZ*500/1000. STAB is 4·BASE for clock code 2'b00 or 2'b01 (4.096 MHz; 00 is treated as the slowest), 2·BASE for 2'b10 (8.192 MHz), and BASE for 2'b11 (16.384 MHz). STAB is BASE for any code when `ext_osc_i` is high.
- R5: During the write, `wr_addr_o` equals parameter `CTRL_ADDR` (default 1). `wr_data_o` carries the captured clock code in bits 6:5, with all other bits zero. Address, data and valid are held unchanged until `wr_ready_i` is high. `wr_ready_i` has no effect outside the write.
- R6: `prog_req_o` rises CFG_CYC = CLK_KHZ*500/1000 cycles after the edge on which the write completed.
- R7: `prog_req_o` stays high until `prog_done_i` is sampled high. `prog_done_i` has no effect in any other phase.
- R8: `out_en_o` and `done_o` rise in the cycle after `prog_done_i` is accepted, and they stay high while power is good.
- R9: A low level on `pwr_good_i` returns all outputs at once to their reset values: device reset low, no write, no request, outputs disabled. After it rises again, the whole sequence restarts.
- R10: `clksel_i` and `ext_osc_i` are captured on the edge that releases the device reset. Later changes affect neither the wait length nor the written clock code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| pwr_good_i | input | 1 | Power-good, low restarts the sequence (asynchronous) |
| clksel_i | input | 2 | Input clock frequency code |
| ext_osc_i | input | 1 | High when an external oscillator is fitted |
| wr_valid_o | output | 1 | Control-register write valid |
| wr_ready_i | input | 1 | Control-register write ready |
| wr_addr_o | output | AW | Control-register write address |
| wr_data_o | output | DW | Control-register write data |
| prog_req_o | output | 1 | Request to run connection-memory block programming |
| prog_done_i | input | 1 | Block programming finished |
| dev_rst_n_o | output | 1 | Device reset, active low |
| tap_rst_n_o | output | 1 | Test-port reset, active low |
| out_en_o | output | 1 | Serial output enable |
| hiz_ind_o | output | 1 | Output high-impedance indicator |
| done_o | output | 1 | Bring-up finished |

## Verification
The hardest situation to reach from the ports is a change of clock code or oscillator option in the middle of the stabilization wait. This case shows whether the captured values or the live inputs set the wait length and the written code. The stimulus starts a sequence with one code, then flips both inputs hundreds of cycles into the wait. The reference model, which captures at reset release, then predicts a different wait and data than the live inputs would. Power-good is also dropped both inside the stabilization wait and while programming is pending, and stray ready and done pulses are applied in phases where they must be ignored.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [2:0] {
    PH_RST     = 3'd0,
    PH_STAB    = 3'd1,
    PH_CFGWR   = 3'd2,
    PH_CFGWAIT = 3'd3,
    PH_PROG    = 3'd4,
    PH_RUN     = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    CKSEL_SLOW = 2'b00,
    CKSEL_4M   = 2'b01,
    CKSEL_8M   = 2'b10,
    CKSEL_16M  = 2'b11
  } cksel_e;

  // Multiplier of the base stabilization time.
  function automatic logic [2:0] stab_mult(input logic [1:0] sel, input logic ext);
    logic [2:0] m;
    if (ext) m = 3'd1;
    else begin
      case (cksel_e'(sel))
        CKSEL_16M: m = 3'd1;
        CKSEL_8M:  m = 3'd2;
        default:   m = 3'd4;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/pwrseq_timer.sv
module pwrseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          clr_i,
  input  logic          en_i,
  output logic [CW-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end

  // Counter must never wrap inside a timed phase
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (en_i && !clr_i && (cnt_o == '1)) |-> 1'b0)
    else $error("timer wrapped");

endmodule

// File: rtl/pwrseq_waitsel.sv
module pwrseq_waitsel
  import pwrseq_pkg::*;
#(
  parameter int CW       = 8,
  parameter int BASE_CYC = 16
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          cap_i,
  input  logic [1:0]    clksel_i,
  input  logic          ext_osc_i,
  output logic [1:0]    sel_q_o,
  output logic [CW-1:0] stab_lim_o
);

  logic       ext_q;
  logic [2:0] mult;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sel_q_o <= 2'b00;
      ext_q   <= 1'b0;
    end else if (cap_i) begin
      sel_q_o <= clksel_i;
      ext_q   <= ext_osc_i;
    end
  end

  assign mult       = stab_mult(sel_q_o, ext_q);
  assign stab_lim_o = CW'(BASE_CYC) * CW'(mult);

  // R10
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !cap_i |=> $stable(sel_q_o) && $stable(stab_lim_o))
    else $error("captured clock code moved");

endmodule

// File: rtl/pwrseq_cfgwr.sv
module pwrseq_cfgwr #(
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int CTRL_ADDR = 1,
  parameter int FLD_LSB   = 5
) (
  input  logic          clk_i,
  input  logic          rst_n_i,
  input  logic          req_i,
  input  logic [1:0]    sel_i,
  input  logic          wr_ready_i,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          xfer_o
);

  always_comb begin
    wr_data_o = '0;
    wr_data_o[FLD_LSB +: 2] = sel_i;
  end

  assign wr_valid_o = req_i;
  assign wr_addr_o  = AW'(CTRL_ADDR);
  assign xfer_o     = req_i && wr_ready_i;

  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (wr_valid_o && !wr_ready_i) |=> wr_valid_o && $stable(wr_data_o) && $stable(wr_addr_o))
    else $error("write dropped under back-pressure");

endmodule

// File: rtl/pwrseq_top.sv
module pwrseq_top
  import pwrseq_pkg::*;
#(
  parameter int CLK_KHZ   = 200000,
  parameter int BASE_US   = 500,
  parameter int CFG_US    = 500,
  parameter int AW        = 8,
  parameter int DW        = 16,
  parameter int CTRL_ADDR = 1
) (
  input  logic          clk_i,
  input  logic          pwr_good_i,
  input  logic [1:0]    clksel_i,
  input  logic          ext_osc_i,
  output logic          wr_valid_o,
  input  logic          wr_ready_i,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o,
  output logic          prog_req_o,
  input  logic          prog_done_i,
  output logic          dev_rst_n_o,
  output logic          tap_rst_n_o,
  output logic          out_en_o,
  output logic          hiz_ind_o,
  output logic          done_o
);

  localparam int RST_CYC  = CLK_KHZ / 1000 + 1;
  localparam int BASE_CYC = CLK_KHZ * BASE_US / 1000;
  localparam int CFG_CYC  = CLK_KHZ * CFG_US / 1000;
  localparam int MAX_A    = (4 * BASE_CYC > CFG_CYC) ? 4 * BASE_CYC : CFG_CYC;
  localparam int MAX_B    = (MAX_A > RST_CYC) ? MAX_A : RST_CYC;
  localparam int CW       = $clog2(MAX_B + 2);

  phase_e        phase_q, phase_d;
  logic [CW-1:0] cnt;
  logic [CW-1:0] stab_lim;
  logic [1:0]    sel_q;
  logic          xfer;
  logic          cap;
  logic          tmr_clr, tmr_en;

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_RST:     if (cnt == CW'(RST_CYC - 1))    phase_d = PH_STAB;
      PH_STAB:    if (cnt == stab_lim - 1'b1)     phase_d = PH_CFGWR;
      PH_CFGWR:   if (xfer)                       phase_d = PH_CFGWAIT;
      PH_CFGWAIT: if (cnt == CW'(CFG_CYC - 1))    phase_d = PH_PROG;
      PH_PROG:    if (prog_done_i)                phase_d = PH_RUN;
      default:                                    phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) phase_q <= PH_RST;
    else             phase_q <= phase_d;
  end

  assign tmr_clr = (phase_d != phase_q);
  assign tmr_en  = (phase_q == PH_RST) || (phase_q == PH_STAB) || (phase_q == PH_CFGWAIT);
  assign cap     = (phase_q == PH_RST) && (phase_d == PH_STAB);

  pwrseq_timer #(.CW(CW)) timer_i (
    .clk_i   (clk_i),
    .rst_n_i (pwr_good_i),
    .clr_i   (tmr_clr),
    .en_i    (tmr_en),
    .cnt_o   (cnt)
  );

  pwrseq_waitsel #(.CW(CW), .BASE_CYC(BASE_CYC)) waitsel_i (
    .clk_i      (clk_i),
    .rst_n_i    (pwr_good_i),
    .cap_i      (cap),
    .clksel_i   (clksel_i),
    .ext_osc_i  (ext_osc_i),
    .sel_q_o    (sel_q),
    .stab_lim_o (stab_lim)
  );

  pwrseq_cfgwr #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR)) cfgwr_i (
    .clk_i      (clk_i),
    .rst_n_i    (pwr_good_i),
    .req_i      (phase_q == PH_CFGWR),
    .sel_i      (sel_q),
    .wr_ready_i (wr_ready_i),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .xfer_o     (xfer)
  );

  assign dev_rst_n_o = (phase_q != PH_RST);
  assign tap_rst_n_o = (phase_q == PH_RUN);
  assign prog_req_o  = (phase_q == PH_PROG);
  assign out_en_o    = (phase_q == PH_RUN);
  assign hiz_ind_o   = ~out_en_o;
  assign done_o      = (phase_q == PH_RUN);

  // Checker-side counters, independent of the phase timer
  logic [CW-1:0] low_run_q, gap_q;

  always_ff @(posedge clk_i or negedge pwr_good_i) begin
    if (!pwr_good_i) begin
      low_run_q <= '0;
      gap_q     <= '0;
    end else begin
      if (!dev_rst_n_o && low_run_q != '1) low_run_q <= low_run_q + 1'b1;
      if (wr_valid_o && wr_ready_i)        gap_q <= '0;
      else if (gap_q != '1)                gap_q <= gap_q + 1'b1;
    end
  end

  // R3
  rst_pulse_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(dev_rst_n_o) |-> (low_run_q >= CW'(RST_CYC)))
    else $error("device reset pulse too short");

  // R6
  cfg_gap_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(prog_req_o) |-> (gap_q >= CW'(CFG_CYC)))
    else $error("programming requested too soon after write");

  // R7
  prog_hold_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (prog_req_o && !prog_done_i) |=> prog_req_o)
    else $error("programming request dropped early");

  // R8
  oe_after_done_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    $rose(out_en_o) |-> $past(prog_req_o && prog_done_i))
    else $error("outputs enabled without programming done");

  // R1
  oe_quiet_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (!dev_rst_n_o || wr_valid_o || prog_req_o) |-> !out_en_o)
    else $error("outputs enabled during bring-up");

  // R8
  done_stay_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    done_o |=> done_o)
    else $error("done dropped");

  // R2
  tap_chk: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
    (wr_valid_o || prog_req_o || !dev_rst_n_o) |-> !tap_rst_n_o)
    else $error("test-port reset released early");

endmodule

// File: tb/pwrseq_top_tb_top.sv
`timescale 1ns/1ps
module pwrseq_top_tb_top;

  localparam int CLK_KHZ = 4000;
  localparam int RST_CYC = CLK_KHZ / 1000 + 1;
  localparam int BASE    = CLK_KHZ * 500 / 1000;
  localparam int CFG     = CLK_KHZ * 500 / 1000;

  logic       clk = 1'b0;
  logic       pg = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       ext = 1'b0;
  logic       rdy = 1'b0;
  logic       pdone = 1'b0;
  logic       wr_valid, prog_req, dev_rst_n, tap_rst_n, out_en, hiz, done;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  always #2.5 clk = ~clk;

  pwrseq_top #(.CLK_KHZ(CLK_KHZ)) dut_i (
    .clk_i(clk), .pwr_good_i(pg), .clksel_i(sel), .ext_osc_i(ext),
    .wr_valid_o(wr_valid), .wr_ready_i(rdy), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .prog_req_o(prog_req), .prog_done_i(pdone), .dev_rst_n_o(dev_rst_n),
    .tap_rst_n_o(tap_rst_n), .out_en_o(out_en), .hiz_ind_o(hiz), .done_o(done)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_en = 1'b0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model: phase 0 reset pulse, 1 stabilize, 2 write,
  // 3 post-write wait, 4 programming, 5 running
  int m_ph = 0;
  int m_cnt = 0;
  int m_lim = 0;
  logic [1:0] m_sel = 2'b00;

  always @(posedge clk or negedge pg) begin
    if (!pg) begin
      m_ph = 0; m_cnt = 0;
    end else begin
      case (m_ph)
        0: begin
          m_cnt++;
          if (m_cnt == RST_CYC) begin
            m_ph = 1; m_cnt = 0; m_sel = sel;
            if (ext || sel == 2'b11) m_lim = BASE;
            else if (sel == 2'b10)   m_lim = 2 * BASE;
            else                     m_lim = 4 * BASE;
          end
        end
        1: begin m_cnt++; if (m_cnt == m_lim) begin m_ph = 2; m_cnt = 0; end end
        2: if (rdy) begin m_ph = 3; m_cnt = 0; end
        3: begin m_cnt++; if (m_cnt == CFG) begin m_ph = 4; m_cnt = 0; end end
        4: if (pdone) m_ph = 5;
        default: m_ph = 5;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk("R3 dev_rst_n", dev_rst_n, m_ph != 0);
      chk("R2 tap_rst_n", tap_rst_n, m_ph == 5);
      chk("R1 out_en", out_en, m_ph == 5);
      chk("R1 hiz", hiz, m_ph != 5);
      chk("R4 wr_valid timing", wr_valid, m_ph == 2);
      if (m_ph == 2) begin
        chk("R5 wr_addr", wr_addr, 32'h1);
        chk("R5 wr_data", wr_data, {25'd0, m_sel, 5'd0});
      end
      chk("R6 prog_req timing", prog_req, m_ph == 4);
      chk("R8 done", done, m_ph == 5);
    end
  end

  task automatic step(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic wait_valid();
    while (!wr_valid) step(1);
  endtask

  task automatic wait_req();
    while (!prog_req) step(1);
  endtask

  task automatic power_up(input logic [1:0] s, input logic e);
    pg = 1'b0; sel = s; ext = e; rdy = 1'b0; pdone = 1'b0;
    step(3);
    pg = 1'b1;
  endtask

  task automatic finish_seq(input int rdy_dly, input int done_dly);
    wait_valid();
    step(rdy_dly);
    rdy = 1'b1; step(1); rdy = 1'b0;
    wait_req();
    step(done_dly);
    pdone = 1'b1; step(1); pdone = 1'b0;
    step(2);
    @(negedge clk);
    chk("R8 outputs enabled after done", {out_en, done, hiz, tap_rst_n}, 4'b1101);
    step(1);
  endtask

  initial begin
    step(2);
    cmp_en = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk("R9 reset state", {dev_rst_n, wr_valid, prog_req, out_en, hiz, done, tap_rst_n}, 7'b0000100);

    // R4 slowest code, early ready ignored during stabilization (R5)
    power_up(2'b00, 1'b0);
    step(50); rdy = 1'b1; step(3); rdy = 1'b0;
    @(negedge clk);
    chk("R5 stray ready ignored", {wr_valid, dev_rst_n}, 2'b01);
    finish_seq(0, 0);

    // R4 4.096 MHz code with back-pressure on the write
    power_up(2'b01, 1'b0);
    finish_seq(7, 3);

    // R4 8.192 MHz code, stray done pulse during stabilization (R7)
    power_up(2'b10, 1'b0);
    step(200); pdone = 1'b1; step(2); pdone = 1'b0;
    @(negedge clk);
    chk("R7 stray done ignored", {out_en, prog_req, done}, 3'b000);
    finish_seq(1, 5);

    // R4 16.384 MHz code
    power_up(2'b11, 1'b0);
    finish_seq(0, 1);

    // R4 external oscillator forces the short wait
    power_up(2'b00, 1'b1);
    finish_seq(2, 0);

    // R10 inputs change mid-wait
    power_up(2'b10, 1'b0);
    step(400); sel = 2'b00; ext = 1'b1;
    wait_valid();
    @(negedge clk);
    chk("R10 captured code", wr_data[6:5], 2'b10);
    finish_seq(0, 0);

    // R9 power loss during stabilization, then restart
    power_up(2'b11, 1'b0);
    step(300);
    pg = 1'b0; #0.5;
    chk("R9 async restart", {dev_rst_n, out_en, hiz}, 3'b001);
    step(2);
    pg = 1'b1;
    finish_seq(0, 0);

    // R9 power loss while programming is pending
    power_up(2'b11, 1'b1);
    wait_valid(); rdy = 1'b1; step(1); rdy = 1'b0;
    wait_req(); step(10);
    pg = 1'b0; step(1);
    @(negedge clk);
    chk("R9 restart from programming", {dev_rst_n, prog_req, out_en, tap_rst_n}, 4'b0000);
    pg = 1'b1;
    finish_seq(0, 0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule